// File: doc/BRIEF.md
# Secure Channel Configuration Register for a DMA Channel

This block is the configuration register of one DMA channel. It stores the channel's enable, the three interrupt enables, the transfer settings (direction, circular mode, address increments, element sizes, priority, memory-to-memory mode) and four protection controls: a secure-configuration flag, secure-source and secure-destination flags, and a privileged-only flag. Every field is driven straight to the channel logic as an output.

Software reaches the register over a simple bus. Each access carries a select, a write strobe, 32 bits of write data and two attributes: secure and privileged. The block filters both reads and writes by those attributes. It freezes the transfer and protection fields while the channel runs. It drops secure flags when the channel is reconfigured as non-secure. It rejects a non-secure attempt to set a secure flag and reports it with a one-cycle pulse.

A write is *granted* when two conditions hold. First, the secure-configuration flag is 0 or the access is secure. Second, the privileged-only flag is 0 or the access is privileged. Field positions: EN bit 0, TCIE 1, HTIE 2, TEIE 3, DIR 4, CIRC 5, PINC 6, MINC 7, PSIZE 9:8, MSIZE 11:10, PL 13:12, M2M 14, SECM 17, SSEC 18, DSEC 19, PRIV 20. All other bits are reserved.

Top module: `dma_seccfg_reg`

## Requirements
- R1: After reset every field is 0 and the illegal pulse is low. Reserved bits (31:21, 16:15) always read 0 and are never stored.
- R2: While EN is 1, a write leaves DIR, PINC, MINC, PSIZE, MSIZE, PL, M2M, SECM, SSEC, DSEC and PRIV unchanged.
- R3: PRIV changes only on a granted, privileged write made while EN is 0. An unprivileged write never alters it.
- R4: SSEC, DSEC and SECM change only on a granted, secure write made while EN is 0. A non-secure write never alters them.
- R5: A non-secure read returns 0 in bits 19:18.
- R6: A non-secure write with bit 18 or bit 19 set changes no field. `illegal_o` is high for exactly the cycle after that write's clock edge, and low after any other cycle.
- R7: A write that takes SECM from 1 to 0 also clears SSEC and DSEC in the same update, whatever the write data holds there.
- R8: While SECM is 1, a non-secure read returns only bits 17 and 20. While PRIV is 1, an unprivileged read does the same.
- R9: M2M and CIRC are never both 1. A write that would make them both 1 keeps both bits at their old values, while the write's other fields still take effect.
- R10: EN, TCIE, HTIE, TEIE and CIRC take the write data on any granted write, whatever the state of EN. A write that is not granted changes nothing. Each field appears on its own output.
- R11: Without select, a write changes nothing. Read data is 0 unless the access is a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Access targets this register |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_wdata_i | input | 32 | Write data |
| bus_sec_i | input | 1 | Access is secure |
| bus_priv_i | input | 1 | Access is privileged |
| bus_rdata_o | output | 32 | Filtered read data (combinational) |
| illegal_o | output | 1 | Illegal secure access pulse |
| ch_en_o | output | 1 | Channel enable |
| ch_tc_ie_o | output | 1 | Transfer-complete interrupt enable |
| ch_ht_ie_o | output | 1 | Half-transfer interrupt enable |
| ch_err_ie_o | output | 1 | Transfer-error interrupt enable |
| ch_dir_o | output | 1 | Transfer direction |
| ch_circ_o | output | 1 | Circular mode |
| ch_pinc_o | output | 1 | Peripheral address increment |
| ch_minc_o | output | 1 | Memory address increment |
| ch_psize_o | output | 2 | Peripheral element size |
| ch_msize_o | output | 2 | Memory element size |
| ch_prio_o | output | 2 | Channel priority level |
| ch_m2m_o | output | 1 | Memory-to-memory mode |
| ch_secm_o | output | 1 | Secure configuration |
| ch_src_sec_o | output | 1 | Secure source |
| ch_dst_sec_o | output | 1 | Secure destination |
| ch_priv_o | output | 1 | Privileged-only configuration |

## Verification
The assertions assume that select, write strobe and both attributes are known 0/1 values at every clock edge. They also assume that the attributes describe the access in the same cycle as the select. They place no limits on the write data, so illegal bit patterns and M2M/CIRC conflicts are fair stimulus. The stimulus is applied on the falling edge and held for one full cycle. The random stream draws any 32-bit data and any attribute pair. It leaves select low in some cycles and biases towards selected writes, so the register goes through the enabled, secure and privileged states.

// File: rtl/dma_seccfg_pkg.sv
package dma_seccfg_pkg;

  localparam int unsigned CFG_W = 32;

  localparam int unsigned EN_B    = 0;
  localparam int unsigned TCIE_B  = 1;
  localparam int unsigned HTIE_B  = 2;
  localparam int unsigned TEIE_B  = 3;
  localparam int unsigned DIR_B   = 4;
  localparam int unsigned CIRC_B  = 5;
  localparam int unsigned PINC_B  = 6;
  localparam int unsigned MINC_B  = 7;
  localparam int unsigned PSIZE_B = 8;
  localparam int unsigned MSIZE_B = 10;
  localparam int unsigned PL_B    = 12;
  localparam int unsigned M2M_B   = 14;
  localparam int unsigned SECM_B  = 17;
  localparam int unsigned SSEC_B  = 18;
  localparam int unsigned DSEC_B  = 19;
  localparam int unsigned PRIV_B  = 20;

  typedef logic [CFG_W-1:0] cfg_word_t;

  function automatic cfg_word_t bits_at(int unsigned lo, int unsigned len);
    cfg_word_t m;
    m = '0;
    for (int unsigned i = 0; i < len; i++) m[lo+i] = 1'b1;
    return m;
  endfunction

  // Fields that follow any granted write.
  localparam cfg_word_t FREE_M = bits_at(EN_B, 4) | bits_at(CIRC_B, 1);
  // Transfer fields frozen while the channel runs.
  localparam cfg_word_t XFER_LOCK_M = bits_at(DIR_B, 1) | bits_at(PINC_B, 9);
  // Secure-only fields.
  localparam cfg_word_t SEC_M = bits_at(SECM_B, 3);
  localparam cfg_word_t SFLAG_M = bits_at(SSEC_B, 2);
  localparam cfg_word_t PRIV_M = bits_at(PRIV_B, 1);
  localparam cfg_word_t LEGAL_M = FREE_M | XFER_LOCK_M | SEC_M | PRIV_M;
  localparam cfg_word_t LOCKED_M = XFER_LOCK_M | SEC_M | PRIV_M;
  localparam cfg_word_t HEADER_M = bits_at(SECM_B, 1) | PRIV_M;

  // Replace the masked bits of old with those of nw.
  function automatic cfg_word_t merge(cfg_word_t old, cfg_word_t nw, cfg_word_t m);
    return (old & ~m) | (nw & m);
  endfunction

  // What a reader with the given attributes may see.
  function automatic cfg_word_t read_view(cfg_word_t q, logic sec, logic prv);
    if ((q[SECM_B] && !sec) || (q[PRIV_B] && !prv)) return q & HEADER_M;
    if (!sec) return q & ~SFLAG_M;
    return q & LEGAL_M;
  endfunction

endpackage

// File: rtl/dma_seccfg_access.sv
module dma_seccfg_access
  import dma_seccfg_pkg::*;
(
  input  logic sel_i,
  input  logic wr_i,
  input  logic sec_i,
  input  logic prv_i,
  input  logic ssec_d_i,
  input  logic dsec_d_i,
  input  logic q_en_i,
  input  logic q_secm_i,
  input  logic q_priv_i,
  output logic wr_fire_o,
  output logic rd_fire_o,
  output logic illegal_evt_o,
  output logic grant_o,
  output logic free_we_o,
  output logic lock_we_o,
  output logic sec_we_o,
  output logic priv_we_o
);

  logic sec_ok;
  logic priv_ok;
  logic wr_apply;

  assign wr_fire_o     = sel_i && wr_i;
  assign rd_fire_o     = sel_i && !wr_i;
  assign sec_ok        = !q_secm_i || sec_i;
  assign priv_ok       = !q_priv_i || prv_i;
  assign grant_o       = sec_ok && priv_ok;
  assign illegal_evt_o = wr_fire_o && !sec_i && (ssec_d_i || dsec_d_i);
  assign wr_apply      = wr_fire_o && !illegal_evt_o && grant_o;

  assign free_we_o = wr_apply;
  assign lock_we_o = wr_apply && !q_en_i;
  assign sec_we_o  = lock_we_o && sec_i;
  assign priv_we_o = lock_we_o && prv_i;

  always_comb begin
    if (sec_we_o) assert (sec_i && grant_o) else $error("p_sec_we_r4");
    if (priv_we_o) assert (prv_i && !q_en_i) else $error("p_priv_we_r3");
  end

endmodule

// File: rtl/dma_seccfg_store.sv
module dma_seccfg_store
  import dma_seccfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      free_we_i,
  input  logic      lock_we_i,
  input  logic      sec_we_i,
  input  logic      priv_we_i,
  input  cfg_word_t wdata_i,
  output cfg_word_t q_o,
  output logic      secm_clear_evt_o,
  output logic      pair_conflict_o
);

  cfg_word_t q;
  cfg_word_t cand;
  cfg_word_t nxt;

  assign secm_clear_evt_o = sec_we_i && q[SECM_B] && !wdata_i[SECM_B];

  always_comb begin
    cand = q;
    if (free_we_i) cand = merge(cand, wdata_i, FREE_M);
    if (lock_we_i) cand = merge(cand, wdata_i, XFER_LOCK_M);
    if (sec_we_i) begin
      cand = merge(cand, wdata_i, SEC_M);
      if (secm_clear_evt_o) cand = cand & ~SFLAG_M;
    end
    if (priv_we_i) cand = merge(cand, wdata_i, PRIV_M);
  end

  assign pair_conflict_o = cand[M2M_B] && cand[CIRC_B];

  always_comb begin
    nxt = cand;
    if (pair_conflict_o) begin
      nxt[M2M_B]  = q[M2M_B];
      nxt[CIRC_B] = q[CIRC_B];
    end
    nxt = nxt & LEGAL_M;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign q_o = q;

  p_pair_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(q[M2M_B] && q[CIRC_B]));

  p_pair_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_conflict_o |=> (q[M2M_B] == $past(q[M2M_B])) && (q[CIRC_B] == $past(q[CIRC_B])));

  p_secm_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q[SECM_B]) |-> (!q[SSEC_B] && !q[DSEC_B]));

  p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~LEGAL_M) == '0);

endmodule

// File: rtl/dma_seccfg_readmux.sv
module dma_seccfg_readmux
  import dma_seccfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rd_fire_i,
  input  logic      sec_i,
  input  logic      prv_i,
  input  cfg_word_t q_i,
  output cfg_word_t rdata_o
);

  assign rdata_o = rd_fire_i ? read_view(q_i, sec_i, prv_i) : '0;

  p_ns_sflags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire_i && !sec_i) |-> (rdata_o[DSEC_B:SSEC_B] == 2'b00));

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire_i |-> (rdata_o == '0));

  p_rsv_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o & ~LEGAL_M) == '0);

  p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire_i && ((q_i[SECM_B] && !sec_i) || (q_i[PRIV_B] && !prv_i)))
      |-> ((rdata_o & ~HEADER_M) == '0));

endmodule

// File: rtl/dma_seccfg_reg.sv
module dma_seccfg_reg
  import dma_seccfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel_i,
  input  logic        bus_wr_i,
  input  logic [31:0] bus_wdata_i,
  input  logic        bus_sec_i,
  input  logic        bus_priv_i,
  output logic [31:0] bus_rdata_o,
  output logic        illegal_o,
  output logic        ch_en_o,
  output logic        ch_tc_ie_o,
  output logic        ch_ht_ie_o,
  output logic        ch_err_ie_o,
  output logic        ch_dir_o,
  output logic        ch_circ_o,
  output logic        ch_pinc_o,
  output logic        ch_minc_o,
  output logic [1:0]  ch_psize_o,
  output logic [1:0]  ch_msize_o,
  output logic [1:0]  ch_prio_o,
  output logic        ch_m2m_o,
  output logic        ch_secm_o,
  output logic        ch_src_sec_o,
  output logic        ch_dst_sec_o,
  output logic        ch_priv_o
);

  cfg_word_t q;
  logic wr_fire, rd_fire, illegal_evt, grant;
  logic free_we, lock_we, sec_we, priv_we;
  logic secm_clear_evt, pair_conflict;
  logic illegal_q;

  dma_seccfg_access u_access (
    .sel_i         (bus_sel_i),
    .wr_i          (bus_wr_i),
    .sec_i         (bus_sec_i),
    .prv_i         (bus_priv_i),
    .ssec_d_i      (bus_wdata_i[SSEC_B]),
    .dsec_d_i      (bus_wdata_i[DSEC_B]),
    .q_en_i        (q[EN_B]),
    .q_secm_i      (q[SECM_B]),
    .q_priv_i      (q[PRIV_B]),
    .wr_fire_o     (wr_fire),
    .rd_fire_o     (rd_fire),
    .illegal_evt_o (illegal_evt),
    .grant_o       (grant),
    .free_we_o     (free_we),
    .lock_we_o     (lock_we),
    .sec_we_o      (sec_we),
    .priv_we_o     (priv_we)
  );

  dma_seccfg_store u_store (
    .clk              (clk),
    .rst_n            (rst_n),
    .free_we_i        (free_we),
    .lock_we_i        (lock_we),
    .sec_we_i         (sec_we),
    .priv_we_i        (priv_we),
    .wdata_i          (bus_wdata_i),
    .q_o              (q),
    .secm_clear_evt_o (secm_clear_evt),
    .pair_conflict_o  (pair_conflict)
  );

  dma_seccfg_readmux u_readmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire_i (rd_fire),
    .sec_i     (bus_sec_i),
    .prv_i     (bus_priv_i),
    .q_i       (q),
    .rdata_o   (bus_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= illegal_evt;
  end

  assign illegal_o    = illegal_q;
  assign ch_en_o      = q[EN_B];
  assign ch_tc_ie_o   = q[TCIE_B];
  assign ch_ht_ie_o   = q[HTIE_B];
  assign ch_err_ie_o  = q[TEIE_B];
  assign ch_dir_o     = q[DIR_B];
  assign ch_circ_o    = q[CIRC_B];
  assign ch_pinc_o    = q[PINC_B];
  assign ch_minc_o    = q[MINC_B];
  assign ch_psize_o   = q[PSIZE_B+1:PSIZE_B];
  assign ch_msize_o   = q[MSIZE_B+1:MSIZE_B];
  assign ch_prio_o    = q[PL_B+1:PL_B];
  assign ch_m2m_o     = q[M2M_B];
  assign ch_secm_o    = q[SECM_B];
  assign ch_src_sec_o = q[SSEC_B];
  assign ch_dst_sec_o = q[DSEC_B];
  assign ch_priv_o    = q[PRIV_B];

  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && q[EN_B]) |=> ((q & LOCKED_M) == ($past(q) & LOCKED_M)));

  p_priv_unpriv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !bus_priv_i) |=> $stable(q[PRIV_B]));

  p_sec_nonsec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !bus_sec_i) |=> $stable(q[DSEC_B:SECM_B]));

  p_illegal_noop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_evt |=> $stable(q));

  p_illegal_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_evt |=> illegal_o);

  p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal_evt |=> !illegal_o);

  p_denied_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !grant) |=> $stable(q));

  p_idle_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(q));

  p_secm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    secm_clear_evt |=> (!q[SSEC_B] && !q[DSEC_B] && !q[SECM_B]));

  p_conflict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_conflict |=> !(q[M2M_B] && q[CIRC_B]));

endmodule

// File: tb/dma_seccfg_reg_bench.sv
`timescale 1ns/1ps
module dma_seccfg_reg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0, sec = 1'b0, prv = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        illegal;
  logic en, tc, ht, te, dir, circ, pinc, minc, m2m, secm, ssec, dsec, pv;
  logic [1:0] psz, msz, pl;

  int checks = 0;
  int fails = 0;
  logic [31:0] model = '0;

  always #2.5 clk = ~clk;

  dma_seccfg_reg u_dma_seccfg_reg (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_wdata_i(wd),
    .bus_sec_i(sec), .bus_priv_i(prv), .bus_rdata_o(rdata), .illegal_o(illegal),
    .ch_en_o(en), .ch_tc_ie_o(tc), .ch_ht_ie_o(ht), .ch_err_ie_o(te), .ch_dir_o(dir),
    .ch_circ_o(circ), .ch_pinc_o(pinc), .ch_minc_o(minc), .ch_psize_o(psz),
    .ch_msize_o(msz), .ch_prio_o(pl), .ch_m2m_o(m2m), .ch_secm_o(secm),
    .ch_src_sec_o(ssec), .ch_dst_sec_o(dsec), .ch_priv_o(pv)
  );

  function automatic logic [31:0] outs();
    return {11'b0, pv, dsec, ssec, secm, 2'b00, m2m, pl, msz, psz, minc, pinc, circ, dir, te, ht, tc, en};
  endfunction

  // Expected register after a write, field by field from the requirements.
  function automatic logic [31:0] mdl_write(logic [31:0] o, logic [31:0] d, logic s, logic p);
    logic [31:0] n;
    logic ok;
    n  = o;
    ok = (!o[17] || s) && (!o[20] || p);
    if (!s && (d[18] || d[19])) return o;        // R6
    if (!ok) return o;                           // R10
    n[3:0] = d[3:0];
    n[5]   = d[5];
    if (!o[0]) begin                             // R2
      n[4]    = d[4];
      n[14:6] = d[14:6];
      if (p) n[20] = d[20];                      // R3
      if (s) begin                               // R4
        n[19:17] = d[19:17];
        if (o[17] && !d[17]) n[19:18] = 2'b00;   // R7
      end
    end
    if (n[14] && n[5]) begin n[14] = o[14]; n[5] = o[5]; end  // R9
    n[31:21] = '0;
    n[16:15] = '0;
    return n;
  endfunction

  function automatic logic [31:0] mdl_read(logic [31:0] o, logic s, logic p);
    if ((o[17] && !s) || (o[20] && !p)) return {11'b0, o[20], 2'b00, o[17], 17'b0};  // R8
    if (!s) return {o[31:20], 2'b00, o[17:0]};  // R5
    return o;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic access(string tag, logic s_l, logic w_l, logic [31:0] d, logic s, logic p);
    logic [31:0] exp_rd;
    logic exp_ill;
    @(negedge clk);
    sel = s_l; wr = w_l; wd = d; sec = s; prv = p;
    #1;
    exp_rd = (s_l && !w_l) ? mdl_read(model, s, p) : 32'h0;
    check({tag, " rdata"}, rdata, exp_rd);
    exp_ill = s_l && w_l && !s && (d[18] || d[19]);
    @(posedge clk);
    if (s_l && w_l) model = mdl_write(model, d, s, p);
    #1;
    check({tag, " fields"}, outs(), model);
    check({tag, " illegal"}, {31'b0, illegal}, {31'b0, exp_ill});
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset fields", outs(), 32'h0);
    check("R1 reset illegal", {31'b0, illegal}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    access("R1 read after reset", 1, 0, 32'h0, 1, 1);
    // All ones: M2M and CIRC clash, reserved dropped.
    access("R9 clash", 1, 1, 32'hFFFF_FFFF, 1, 1);
    check("R9 clash value", outs(), 32'h001E_3FDF);
    // Channel now running: only free fields follow.
    access("R2 locked", 1, 1, 32'h0000_0000, 1, 1);
    check("R2 dir kept", {31'b0, dir}, 32'h1);
    check("R10 en cleared", {31'b0, en}, 32'h0);
    access("R8 nonsec read", 1, 0, 32'h0, 0, 1);
    access("R8 unpriv read", 1, 0, 32'h0, 1, 0);
    access("R3 unpriv write", 1, 1, 32'h0000_0000, 1, 0);
    check("R3 priv kept", {31'b0, pv}, 32'h1);
    access("R7 secm clear", 1, 1, 32'h001C_0000, 1, 1);
    check("R7 flags cleared", {30'b0, dsec, ssec}, 32'h0);
    access("R4 set flags", 1, 1, 32'h001C_0000, 1, 1);
    check("R4 flags set", {30'b0, dsec, ssec}, 32'h3);
    access("R5 nonsec read", 1, 0, 32'h0, 0, 1);
    access("R4 secure read", 1, 0, 32'h0, 1, 1);
    access("R6 illegal write", 1, 1, 32'h0014_0001, 0, 1);
    access("R6 pulse ends", 0, 0, 32'h0, 0, 0);
    access("R4 nonsec clear", 1, 1, 32'h0010_0000, 0, 1);
    check("R4 flags kept", {30'b0, dsec, ssec}, 32'h3);
    access("R9 circ on", 1, 1, 32'h001C_0020, 1, 1);
    access("R9 both", 1, 1, 32'h001C_4022, 1, 1);
    check("R9 pair kept", {30'b0, m2m, circ}, 32'h1);
    access("R9 m2m only", 1, 1, 32'h001C_4000, 1, 1);
    check("R9 m2m set", {30'b0, m2m, circ}, 32'h2);
    access("R11 unselected", 0, 1, 32'hFFFF_FFFF, 1, 1);
    access("R10 en set", 1, 1, 32'h001C_400F, 1, 1);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      logic s_l, w_l;
      d   = $urandom;
      s_l = ($urandom % 8) != 0;
      w_l = ($urandom % 3) != 0;
      if (($urandom % 4) == 0) d[19:18] = 2'b00;
      if (($urandom % 3) == 0) d[0] = 1'b0;
      access("R10 random", s_l, w_l, d, 1'($urandom), 1'($urandom));
    end
    finish_run();
  end

endmodule